// File: doc/BRIEF.md
# Receive Frame Staging Buffer with Commit and Rollback

This block sits between a byte-wide receive stream and a consumer that must only ever see payload from frames that passed checking. Every incoming frame is written speculatively into a power-of-two byte store ahead of a committed write pointer. A separate checker, which is not part of this block, delivers a pass or fail verdict once the frame has ended. A pass moves the committed pointer up to the speculative one. A fail, or a frame that cannot fit, moves the speculative pointer back, so none of its bytes ever reach the reader.

The reader sees a plain FIFO. It has an empty flag, a count of readable bytes and registered read data that appears one clock after the read request. Because the count covers only committed bytes, a consumer may issue that many back-to-back reads without watching empty. A flush input empties everything in a single clock and abandons any frame in progress.

Capture is run by a four-state machine. `CAP_IDLE` waits for a rising edge of `in_valid`. `CAP_BODY` stores beats until the end beat. `CAP_VERDICT` holds the finished frame until its verdict arrives. `CAP_SKIP` swallows the rest of a frame that ran out of room. The transitions are as follows:
- IDLE to BODY on a rising edge of `in_valid`.
- IDLE to VERDICT when that first beat is also the end beat.
- BODY to VERDICT on the end beat.
- BODY or IDLE to SKIP on a beat with no room. When that beat is the end beat, the machine goes to IDLE instead.
- SKIP to IDLE on the end beat.
- VERDICT to IDLE when a verdict arrives.
- VERDICT straight into a new frame (BODY, VERDICT or SKIP) when `in_valid` rises. The pending frame is then rejected.
- Any state to IDLE on flush.

Top module: `rx_frame_stage`

## Requirements
- R1: After reset `rd_empty` is 1, `rd_count` is 0 and `ovf_seen` is 0.
- R2: A frame starts only on a cycle where `in_valid` is 1 and was 0 the cycle before; the beat with `in_eop`=1 is its last byte, and further cycles with `in_valid` held high after that beat store nothing.
- R3: `chk_done`=1 with `chk_pass`=1 while a finished frame awaits its verdict commits it: `rd_count` rises by the frame length on the clock edge that samples the verdict.
- R4: `chk_done`=1 with `chk_pass`=0 discards the waiting frame; the committed pointer moves only on a sampled pass verdict, and a later committed frame's bytes follow the earlier committed data directly.
- R5: A new frame start while a finished frame still awaits its verdict rejects the waiting frame, and the new frame is captured normally.
- R6: A beat arriving when the store holds 2^ADDR_W bytes (committed plus speculative, counted from the read pointer) drops the whole frame, sets `ovf_seen`, and skips to the frame's end beat; `ovf_seen` stays 1 until flush, and a frame that exactly fills the store is accepted.
- R7: `rd_data` carries the byte requested by `rd_en` one clock later, bytes in arrival order.
- R8: `rd_count` equals the number of committed unread bytes (at most 2^ADDR_W), `rd_empty` is 1 exactly when it is 0, and a burst of `rd_count` reads returns valid data.
- R9: `rd_en` while `rd_empty`=1 has no effect on the read pointer or the count.
- R10: `flush`=1 makes `rd_empty`=1, `rd_count`=0 and `ovf_seen`=0 on the next cycle and abandons a frame in progress, whose remaining beats are ignored.
- R11: A verdict pulse when no finished frame is waiting is ignored.
- R12: Bytes of a frame are not counted or readable before its pass verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receive beat valid; its rising edge opens a frame |
| in_eop | input | 1 | Marks the last beat of a frame |
| in_data | input | DATA_W | Receive byte |
| chk_done | input | 1 | Verdict strobe from the external frame checker |
| chk_pass | input | 1 | Verdict value, 1 = frame accepted |
| flush | input | 1 | Empties the store and abandons capture |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read byte, one clock after `rd_en` |
| rd_empty | output | 1 | No committed byte to read |
| rd_count | output | ADDR_W+1 | Committed unread bytes |
| ovf_seen | output | 1 | Sticky flag: a frame was dropped for lack of room |

## Verification
The bound checker watches, on every cycle, the following properties:
- The committed pointer moves only on a pass verdict.
- Nothing is written in the cycle after an end beat.
- A read while empty leaves the read pointer alone.
- The fill count stays within the store, with committed data never ahead of speculative data.
- Flush clears the store and the sticky flag.
- The sticky flag holds once set.

Only the directed scenarios show the data path end to end: read data order and latency, rollback after a fail or an early restart, ignored stray verdicts, and the exact-fill boundary next to an overflowing frame.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE    = 2'd0,
        CAP_BODY    = 2'd1,
        CAP_VERDICT = 2'd2,
        CAP_SKIP    = 2'd3
    } cap_state_e;
endpackage

// File: rtl/rxs_byte_ram.sv
module rxs_byte_ram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/rxs_capture_ctl.sv
module rxs_capture_ctl
    import rxs_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_eop,
    input  logic              chk_done,
    input  logic              chk_pass,
    input  logic              flush,
    input  logic [ADDR_W:0]   rd_ptr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [ADDR_W:0]   commit_ptr,
    output logic [ADDR_W:0]   spec_ptr,
    output logic              ovf_seen
);
    localparam int PW = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] FULL_FILL = PW'(DEPTH);

    cap_state_e    state_q, state_n;
    logic          valid_q;
    logic [PW-1:0] commit_n, spec_n, base;
    logic          sticky_n, take_beat, rise;

    assign rise = in_valid && !valid_q;

    // next-state and output decode
    always_comb begin
        state_n   = state_q;
        commit_n  = commit_ptr;
        spec_n    = spec_ptr;
        sticky_n  = ovf_seen;
        take_beat = 1'b0;
        base      = spec_ptr;
        mem_we    = 1'b0;
        unique case (state_q)
            CAP_IDLE: begin
                if (rise) begin
                    take_beat = 1'b1;
                    base      = commit_ptr;
                end
            end
            CAP_BODY: begin
                if (in_valid) begin
                    take_beat = 1'b1;
                    base      = spec_ptr;
                end
            end
            CAP_VERDICT: begin
                if (chk_done && chk_pass) begin
                    commit_n = spec_ptr;
                end
                if (chk_done || rise) begin
                    state_n = CAP_IDLE;
                    spec_n  = commit_n;
                end
                if (rise) begin
                    take_beat = 1'b1;
                    base      = commit_n;
                end
            end
            CAP_SKIP: begin
                if (in_valid && in_eop) begin
                    state_n = CAP_IDLE;
                end
            end
        endcase

        if (take_beat) begin
            if ((base - rd_ptr) == FULL_FILL) begin
                spec_n   = commit_n;
                sticky_n = 1'b1;
                state_n  = in_eop ? CAP_IDLE : CAP_SKIP;
            end else begin
                mem_we  = 1'b1;
                spec_n  = base + PW'(1);
                state_n = in_eop ? CAP_VERDICT : CAP_BODY;
            end
        end

        if (flush) begin
            state_n  = CAP_IDLE;
            commit_n = '0;
            spec_n   = '0;
            sticky_n = 1'b0;
            mem_we   = 1'b0;
        end
    end

    assign mem_waddr = base[ADDR_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= CAP_IDLE;
            valid_q    <= 1'b0;
            commit_ptr <= '0;
            spec_ptr   <= '0;
            ovf_seen   <= 1'b0;
        end else begin
            state_q    <= state_n;
            valid_q    <= in_valid;
            commit_ptr <= commit_n;
            spec_ptr   <= spec_n;
            ovf_seen   <= sticky_n;
        end
    end
endmodule

// File: rtl/rxs_read_side.sv
module rxs_read_side #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   commit_ptr,
    output logic [ADDR_W:0]   rd_ptr,
    output logic [ADDR_W:0]   rd_count,
    output logic              rd_empty,
    output logic              ram_re,
    output logic [ADDR_W-1:0] ram_raddr
);
    localparam int PW = ADDR_W + 1;

    assign rd_count  = commit_ptr - rd_ptr;
    assign rd_empty  = (rd_count == '0);
    assign ram_re    = rd_en && !rd_empty && !flush;
    assign ram_raddr = rd_ptr[ADDR_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
        end else if (ram_re) begin
            rd_ptr <= rd_ptr + PW'(1);
        end
    end
endmodule

// File: rtl/rx_frame_stage.sv
module rx_frame_stage #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              chk_done,
    input  logic              chk_pass,
    input  logic              flush,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic [ADDR_W:0]   rd_count,
    output logic              ovf_seen
);
    logic [ADDR_W:0]   rd_ptr;
    logic [ADDR_W:0]   commit_ptr;
    logic [ADDR_W:0]   spec_ptr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic              ram_re;
    logic [ADDR_W-1:0] ram_raddr;

    rxs_capture_ctl #(.ADDR_W(ADDR_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_eop     (in_eop),
        .chk_done   (chk_done),
        .chk_pass   (chk_pass),
        .flush      (flush),
        .rd_ptr     (rd_ptr),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .commit_ptr (commit_ptr),
        .spec_ptr   (spec_ptr),
        .ovf_seen   (ovf_seen)
    );

    rxs_read_side #(.ADDR_W(ADDR_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .rd_en      (rd_en),
        .commit_ptr (commit_ptr),
        .rd_ptr     (rd_ptr),
        .rd_count   (rd_count),
        .rd_empty   (rd_empty),
        .ram_re     (ram_re),
        .ram_raddr  (ram_raddr)
    );

    rxs_byte_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (in_data),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/rx_frame_stage_chk.sv
module rx_frame_stage_chk #(
    parameter int ADDR_W = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_eop,
    input logic            chk_done,
    input logic            chk_pass,
    input logic            flush,
    input logic            rd_en,
    input logic            rd_empty,
    input logic [ADDR_W:0] rd_count,
    input logic            ovf_seen,
    input logic [ADDR_W:0] rd_ptr,
    input logic [ADDR_W:0] commit_ptr,
    input logic [ADDR_W:0] spec_ptr,
    input logic            mem_we
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] FULL_FILL = PW'(1 << ADDR_W);

    logic [PW-1:0] fill_commit, fill_spec;
    assign fill_commit = commit_ptr - rd_ptr;
    assign fill_spec   = spec_ptr - rd_ptr;

    // R8: readable count never exceeds the store
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_count <= FULL_FILL);

    // R12: committed data never runs ahead of speculative data
    p_spec_ahead_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_spec <= FULL_FILL) && (fill_commit <= fill_spec));

    // R4: the committed pointer moves only on a pass verdict
    p_commit_on_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !flush && !(chk_done && chk_pass) |=> commit_ptr == $past(commit_ptr));

    // R2: no byte is stored the cycle after an end beat
    p_quiet_after_eop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_eop |=> !mem_we);

    // R9: reading an empty store leaves the read pointer alone
    p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_empty && !flush |=> rd_ptr == $past(rd_ptr));

    // R10: flush empties the store and clears the sticky flag
    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> rd_empty && (rd_count == '0) && !ovf_seen);

    // R6: sticky drop flag holds until flush
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_seen && !flush |=> ovf_seen);
endmodule

bind rx_frame_stage rx_frame_stage_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_eop     (in_eop),
    .chk_done   (chk_done),
    .chk_pass   (chk_pass),
    .flush      (flush),
    .rd_en      (rd_en),
    .rd_empty   (rd_empty),
    .rd_count   (rd_count),
    .ovf_seen   (ovf_seen),
    .rd_ptr     (rd_ptr),
    .commit_ptr (commit_ptr),
    .spec_ptr   (spec_ptr),
    .mem_we     (mem_we)
);

// File: tb/rx_frame_stage_test.sv
module rx_frame_stage_test;
    localparam int ADDR_W = 11;
    localparam int DEPTH  = 1 << ADDR_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_eop = 1'b0;
    logic [7:0]      in_data = '0;
    logic            chk_done = 1'b0;
    logic            chk_pass = 1'b0;
    logic            flush = 1'b0;
    logic            rd_en = 1'b0;
    logic [7:0]      rd_data;
    logic            rd_empty;
    logic [ADDR_W:0] rd_count;
    logic            ovf_seen;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rx_frame_stage #(.ADDR_W(ADDR_W), .DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop),
        .in_data(in_data), .chk_done(chk_done), .chk_pass(chk_pass),
        .flush(flush), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
        .rd_count(rd_count), .ovf_seen(ovf_seen)
    );

    task automatic expect_eq(input string req, input int actual, input int expected);
        n_cmp++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic send_frame(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'((seed + i) & 8'hFF);
            in_eop   = (i == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic verdict(input logic pass);
        @(negedge clk);
        chk_done = 1'b1;
        chk_pass = pass;
        @(negedge clk);
        chk_done = 1'b0;
        chk_pass = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic read_expect(input string req, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) expect_eq(req, rd_data, (seed + i - 1) & 8'hFF);
            rd_en = 1'b1;
        end
        @(negedge clk);
        rd_en = 1'b0;
        expect_eq(req, rd_data, (seed + n - 1) & 8'hFF);
    endtask

    task automatic t_reset();
        expect_eq("R1 empty", rd_empty, 1);
        expect_eq("R1 count", rd_count, 0);
        expect_eq("R1 ovf", ovf_seen, 0);
    endtask

    task automatic t_pass();
        send_frame(5, 'h10);
        @(negedge clk);
        expect_eq("R12 count before verdict", rd_count, 0);
        expect_eq("R12 empty before verdict", rd_empty, 1);
        verdict(1'b1);
        expect_eq("R3 count after pass", rd_count, 5);
        expect_eq("R8 not empty", rd_empty, 0);
        read_expect("R7 data", 5, 'h10);
        expect_eq("R8 empty after burst", rd_empty, 1);
        expect_eq("R8 count after burst", rd_count, 0);
    endtask

    task automatic t_fail();
        send_frame(4, 'h20);
        verdict(1'b0);
        expect_eq("R4 count after fail", rd_count, 0);
        send_frame(3, 'h30);
        verdict(1'b1);
        expect_eq("R4 count next frame", rd_count, 3);
        read_expect("R4 data after rollback", 3, 'h30);
    endtask

    task automatic t_hold_valid();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'('h40 + i);
            in_eop   = (i == 2);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_eop   = 1'b0;
        verdict(1'b1);
        expect_eq("R2 beats after eop ignored", rd_count, 3);
        read_expect("R2 data", 3, 'h40);
    endtask

    task automatic t_early_start();
        send_frame(4, 'h50);
        send_frame(2, 'h60);
        verdict(1'b1);
        expect_eq("R5 only new frame kept", rd_count, 2);
        read_expect("R5 data", 2, 'h60);
    endtask

    task automatic t_stray_verdict();
        verdict(1'b1);
        expect_eq("R11 idle verdict ignored", rd_count, 0);
        send_frame(2, 'h70);
        verdict(1'b1);
        verdict(1'b1);
        expect_eq("R11 repeat verdict ignored", rd_count, 2);
        read_expect("R11 data", 2, 'h70);
    endtask

    task automatic t_empty_read();
        @(negedge clk);
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        expect_eq("R9 count", rd_count, 0);
        expect_eq("R9 empty", rd_empty, 1);
        send_frame(2, 'h78);
        verdict(1'b1);
        expect_eq("R9 count after frame", rd_count, 2);
        read_expect("R9 data unaffected", 2, 'h78);
    endtask

    task automatic t_overflow();
        do_flush();
        send_frame(2000, 0);
        verdict(1'b1);
        expect_eq("R8 large count", rd_count, 2000);
        send_frame(100, 'h80);
        verdict(1'b1);
        expect_eq("R6 overflow frame dropped", rd_count, 2000);
        expect_eq("R6 sticky set", ovf_seen, 1);
        send_frame(DEPTH - 2000, 'h90);
        verdict(1'b1);
        expect_eq("R6 exact fill accepted", rd_count, DEPTH);
        expect_eq("R6 sticky holds", ovf_seen, 1);
        read_expect("R6 old data intact", 2000, 0);
        read_expect("R6 fill frame data", DEPTH - 2000, 'h90);
        expect_eq("R8 drained", rd_empty, 1);
    endtask

    task automatic t_flush();
        send_frame(5, 'hB0);
        verdict(1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'('hC0 + i);
        end
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        expect_eq("R10 count", rd_count, 0);
        expect_eq("R10 empty", rd_empty, 1);
        expect_eq("R10 ovf cleared", ovf_seen, 0);
        in_eop = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_eop   = 1'b0;
        verdict(1'b1);
        expect_eq("R10 abandoned frame", rd_count, 0);
        send_frame(2, 'hA0);
        verdict(1'b1);
        expect_eq("R10 fresh frame", rd_count, 2);
        read_expect("R10 data", 2, 'hA0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_fail();
        t_hold_valid();
        t_early_start();
        t_stray_verdict();
        t_empty_read();
        t_overflow();
        t_flush();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule